// File: doc/BRIEF.md
# Dual-Clock Cascadable Up/Down Counter

A 4-bit binary counter whose direction depends on which of two count inputs rises. A rising edge on the up input moves the count one step higher, but only while the down input is high. A rising edge on the down input moves it one step lower, but only while the up input is high. The count wraps at both ends. The count inputs are asynchronous strobes. Each one passes through a synchronizer on a fast system clock, and its rising edge is detected there. All bits of the count register then move together on a single system-clock edge.

Two level-sensitive controls act on the output without waiting for a count edge. An active-high clear forces the count to zero and overrides everything else. An active-low load makes the count follow the data input for as long as it is held low. Both controls are expected to be synchronous to the system clock.

The block has two active-low cascade outputs, carry and borrow. Each is a combinational pulse gated by its raw count input. Carry is low while the count is at its maximum and the up input is low. Borrow is low while the count is zero and the down input is low. Wiring carry to the next stage's up input and borrow to the next stage's down input chains stages into a wider counter. Reloading on borrow turns a stage into a modulo-N divider.

Top module: `twin_clk_counter`

## Requirements
- R1: Counting is pure binary on WIDTH bits (default 4). An up step from 15 gives 0, and a down step from 0 gives 15.
- R2: A rising edge on `cnt_up_i` while `cnt_dn_i` is high raises the count by exactly one. The count appears at `count_o` on the third system-clock rising edge after the input rises.
- R3: A rising edge on `cnt_dn_i` while `cnt_up_i` is high lowers the count by exactly one, with the same latency as R2.
- R4: While `load_n_i` is 0, `count_o` equals `data_i`, and count edges have no effect. After `load_n_i` returns to 1, counting continues from the last loaded value.
- R5: While `clear_i` is 1, `count_o` is 0, whatever the state of load and the count inputs. Once clear is released, the count stays 0 until the next count step.
- R6: `borrow_n_o` is 0 exactly when `count_o` is 0 and `cnt_dn_i` is 0. Otherwise it is 1.
- R7: `carry_n_o` is 0 exactly when `count_o` is all ones and `cnt_up_i` is 0. Otherwise it is 1.
- R8: Two stages form a correct two-digit counter when the lower stage's `carry_n_o` drives the upper stage's `cnt_up_i` and its `borrow_n_o` drives the upper stage's `cnt_dn_i`. This holds in both directions.
- R9: All count bits change on one system-clock edge, and between two edges with no load or clear the count changes by at most one step.
- R10: The count does not change in two cases: a count input rises while the other input is low, or both inputs rise in the same system-clock cycle.
- R11: Driving `load_n_i` low whenever `borrow_n_o` is low, with `data_i` = N, makes the stage step down through N-1 … 0 and repeat with period N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cnt_up_i | input | 1 | Up count strobe; a rising edge counts up |
| cnt_dn_i | input | 1 | Down count strobe; a rising edge counts down |
| load_n_i | input | 1 | Active-low parallel load |
| clear_i | input | 1 | Active-high clear; highest priority |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry pulse for cascading |
| borrow_n_o | output | 1 | Active-low borrow pulse for cascading |

## Verification
The bench drives isolated up pulses, isolated down pulses, and runs across both wrap points. These separate the direction steering from the rollover arithmetic. It also applies edges while the other input is low and edges on both inputs in the same cycle. Those cases show whether the qualifying level is really tested, rather than any edge being counted. Load and clear are held while count pulses arrive, to confirm their priority. A second stage chained through carry and borrow, and a borrow-driven reload loop, show that the cascade pulses have the correct timing relative to the count update.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/twc_edge_sync.sv
// Synchronizes an asynchronous strobe to clk and flags its rising edges.
// Every flop resets to 1 (the idle level), so leaving reset cannot create an edge.
module twc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/twc_step_decode.sv
// Chooses the count direction from the two synchronized strobes.
module twc_step_decode
  import twc_pkg::*;
(
  input  logic  up_level,
  input  logic  up_rise,
  input  logic  dn_level,
  input  logic  dn_rise,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise && dn_level && !dn_rise)
      step_o = STEP_INC;
    else if (dn_rise && up_level && !up_rise)
      step_o = STEP_DEC;
  end
endmodule

// File: rtl/twc_ripple_out.sv
// Cascade pulses, gated by the raw count strobes.
module twc_ripple_out #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_raw_i,
  input  logic             dn_raw_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n_o  = ~((count_i == TOP) & ~up_raw_i);
  assign borrow_n_o = ~((count_i == '0)  & ~dn_raw_i);
endmodule

// File: rtl/twin_clk_counter.sv
module twin_clk_counter
  import twc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             load_n_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam int               NUM_STROBES = 2;
  localparam int               IDX_UP      = 0;
  localparam int               IDX_DN      = 1;
  localparam logic [WIDTH-1:0] ONE         = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [NUM_STROBES-1:0] raw, lvl, rise;
  step_e                  step;
  logic [WIDTH-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;

  assign raw[IDX_UP] = cnt_up_i;
  assign raw[IDX_DN] = cnt_dn_i;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
    twc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g])
    );
  end

  twc_step_decode u_dec (
    .up_level (lvl[IDX_UP]),
    .up_rise  (rise[IDX_UP]),
    .dn_level (lvl[IDX_DN]),
    .dn_rise  (rise[IDX_DN]),
    .step_o   (step)
  );

  // Next state: clear, then load, then count.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!load_n_i) begin
      cnt_d  = data_i;
      cnt_en = 1'b1;
    end else begin
      case (step)
        STEP_INC: begin cnt_d = cnt_q + ONE; cnt_en = 1'b1; end
        STEP_DEC: begin cnt_d = cnt_q - ONE; cnt_en = 1'b1; end
        default:  begin cnt_d = cnt_q;       cnt_en = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // Clear and load reach the output without waiting for a clock edge.
  always_comb begin
    if (clear_i)        count_o = '0;
    else if (!load_n_i) count_o = data_i;
    else                count_o = cnt_q;
  end

  twc_ripple_out #(.WIDTH(WIDTH)) u_ripple (
    .count_i    (count_o),
    .up_raw_i   (cnt_up_i),
    .dn_raw_i   (cnt_dn_i),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );
endmodule

// File: rtl/twc_checker.sv
module twc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_up_i,
  input logic             cnt_dn_i,
  input logic             load_n_i,
  input logic             clear_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R5: after clear is released, with no load, the held count is zero.
  a_r5_clear_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clear_i) && load_n_i) |-> (count_o == '0));

  // R4: when load is released, the register holds the last loaded value.
  a_r4_load_retained: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(load_n_i) && !clear_i && !$past(clear_i)) |-> (count_o == $past(data_i)));

  // R9: with no load or clear, the count moves by at most one step per edge.
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_i && !clear_i && $past(load_n_i) && !$past(clear_i)) |->
      (count_o == $past(count_o) || count_o == $past(count_o) + ONE ||
       count_o == $past(count_o) - ONE));

  // R6: a borrow pulse happens only at zero with the down input low.
  a_r6_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n_o |-> (count_o == '0 && !cnt_dn_i));

  // R7: a carry pulse happens only at the maximum with the up input low.
  a_r7_carry_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> (count_o == {WIDTH{1'b1}} && !cnt_up_i));
endmodule

bind twin_clk_counter twc_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/twin_clk_counter_tb.sv
`timescale 1ns/1ps
module twin_clk_counter_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         up, dn, load_n, clr;
  logic [W-1:0] data;
  logic [W-1:0] cnt, hi_cnt;
  logic         carry_n, borrow_n, hi_carry_n, hi_borrow_n;
  int           n_chk = 0;
  int           n_fail = 0;

  always #5 clk = ~clk;

  twin_clk_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(up), .cnt_dn_i(dn),
    .load_n_i(load_n), .clear_i(clr), .data_i(data),
    .count_o(cnt), .carry_n_o(carry_n), .borrow_n_o(borrow_n));

  twin_clk_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(carry_n), .cnt_dn_i(borrow_n),
    .load_n_i(1'b1), .clear_i(clr), .data_i('0),
    .count_o(hi_cnt), .carry_n_o(hi_carry_n), .borrow_n_o(hi_borrow_n));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    @(negedge clk); up = 1'b0; idle(4); up = 1'b1; idle(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn = 1'b0; idle(4); dn = 1'b1; idle(4);
  endtask

  task automatic load_value(input logic [W-1:0] v);
    @(negedge clk); data = v; load_n = 1'b0; idle(1); load_n = 1'b1; idle(1);
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 1'b1; idle(1); clr = 1'b0; idle(1);
  endtask

  task automatic t_reset();
    chk("R5 reset count", cnt, 0);
    chk("R6 reset borrow", borrow_n, 1);
    chk("R7 reset carry", carry_n, 1);
  endtask

  task automatic t_up_down();
    pulse_up(); pulse_up(); pulse_up();
    chk("R2 three ups", cnt, 3);
    pulse_dn();
    chk("R3 one down", cnt, 2);
    // R2 latency: visible after the third rising edge, not before
    @(negedge clk); up = 1'b0; idle(4); up = 1'b1;
    idle(2);
    chk("R2 before latency", cnt, 2);
    idle(1);
    chk("R2 after latency", cnt, 3);
    idle(2);
  endtask

  task automatic t_wrap_and_carry();
    load_value(4'd15);
    @(negedge clk); up = 1'b0; #1;
    chk("R7 carry low at top", carry_n, 0);
    idle(4); up = 1'b1; #1;
    chk("R7 carry high once up rises", carry_n, 1);
    idle(4);
    chk("R1 up wrap 15->0", cnt, 0);
    @(negedge clk); dn = 1'b0; #1;
    chk("R6 borrow low at zero", borrow_n, 0);
    idle(4); dn = 1'b1; idle(4);
    chk("R1 down wrap 0->15", cnt, 15);
    chk("R6 borrow high off zero", borrow_n, 1);
  endtask

  task automatic t_load();
    @(negedge clk); data = 4'd9; load_n = 1'b0; #1;
    chk("R4 follows data", cnt, 9);
    data = 4'd6; #1;
    chk("R4 tracks data change", cnt, 6);
    up = 1'b0; idle(4); up = 1'b1; idle(4);
    chk("R4 count ignored under load", cnt, 6);
    load_n = 1'b1; idle(2);
    chk("R4 value retained", cnt, 6);
    pulse_up();
    chk("R4 resume from loaded", cnt, 7);
  endtask

  task automatic t_clear();
    @(negedge clk); data = 4'd12; load_n = 1'b0; clr = 1'b1; #1;
    chk("R5 clear over load", cnt, 0);
    up = 1'b0; idle(4); up = 1'b1; idle(4);
    chk("R5 clear over count", cnt, 0);
    load_n = 1'b1; idle(1); clr = 1'b0; idle(2);
    chk("R5 zero after clear", cnt, 0);
  endtask

  task automatic t_qualify();
    load_value(4'd5);
    @(negedge clk); dn = 1'b0; idle(4);
    up = 1'b0; idle(4); up = 1'b1; idle(4);
    chk("R10 up edge with down low", cnt, 5);
    dn = 1'b1; idle(4);
    chk("R3 down rise with up high", cnt, 4);
    @(negedge clk); up = 1'b0; dn = 1'b0; idle(4);
    up = 1'b1; dn = 1'b1; idle(5);
    chk("R10 both rise together", cnt, 4);
  endtask

  task automatic t_cascade();
    clear_all();
    for (int i = 0; i < 17; i++) pulse_up();
    chk("R8 low digit after 17", cnt, 1);
    chk("R8 high digit after 17", hi_cnt, 1);
    pulse_dn(); pulse_dn();
    chk("R8 low digit after borrow", cnt, 15);
    chk("R8 high digit after borrow", hi_cnt, 0);
  endtask

  task automatic t_modulo();
    logic [W-1:0] model;
    load_value(4'd0);
    model = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); dn = 1'b0; #1;
      if (!borrow_n) begin
        load_n = 1'b0; data = 4'd4; idle(1); load_n = 1'b1;
      end
      if (model == 0) model = 4'd4;
      idle(3); dn = 1'b1; idle(4);
      model = model - 1'b1;
      chk("R11 modulo-4 sequence", cnt, model);
    end
  endtask

  initial begin
    rst_n = 1'b0; up = 1'b1; dn = 1'b1; load_n = 1'b1; clr = 1'b0; data = '0;
    idle(3); rst_n = 1'b1; idle(2);
    t_reset();
    t_up_down();
    t_wrap_and_carry();
    t_load();
    t_clear();
    t_qualify();
    t_cascade();
    t_modulo();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule